// File: doc/BRIEF.md
# Seed Source Selector with Bit-Serial Test Seed

This block assembles the seed and personalization inputs for a downstream deterministic random generator. A seed can come from one of three places: a bank of software-written seed words, a 128-bit test seed that software fills one bit per register write, or a wide entropy input from a noise source. The personalization value comes from a second bank of software-written words. Software can also force it to zero.

When a reseed is requested, the block captures the chosen seed and personalization value into output registers and pulses a reseed strobe. A reseed can come from an external request or from an accepted test-bit write. An accepted test-bit write also raises a regeneration strobe in the next cycle. The block also decodes reads in its own address window. The stored secrets never appear on the read port: a read anywhere in that window returns the status word supplied from outside.

Top module: `seedsel_core`

## Requirements
- R1: A write to word address 16+i (i = 0..11) stores the data as seed word i. Word i occupies seed bits [32i+31:32i].
- R2: At a reseed, the captured seed is chosen in this order. The external seed words win when `ctl_ext_seed` is 1. Otherwise, when `ctl_test_mode` is 1, the 128-bit test seed is used, zero-extended to 384 bits. Otherwise `entropy_i` is used.
- R3: A write to word address 32+i stores personalization word i in bits [32i+31:32i]. At a reseed, `pers_o` takes those words, or all zeros when `ctl_pers_off` is 1.
- R4: Each accepted write to word address 5 shifts the test seed left by one place. Bit 0 of the data enters at bit 0. Bit 63 moves into bit 64, and bit 127 is lost.
- R5: A write to address 5 is accepted only when all of the following hold: `ctl_test_mode` = 1, `ctl_src_en` = 1, `osc_en` = 1, `hold_rst` = 0 and `ctl_soft_rst` = 0. A write that is not accepted leaves the test seed unchanged and raises no strobe.
- R6: An accepted test-bit write raises `reseed_o` for exactly the one cycle after the write cycle. `regen_o` then follows for exactly the one cycle after that. The new test seed is already in `seed_o` while `reseed_o` is high.
- R7: A `reseed_req` pulse raises `reseed_o` in the next cycle, and `regen_o` stays low.
- R8: `seed_o` and `pers_o` change only in a cycle where `reseed_o` is 1. Seed-word or personalization-word writes alone leave them unchanged.
- R9: A read (`rd_en`) raises `rd_valid_o` in the next cycle. For addresses 16 to 43 inclusive, including the unused addresses 28 to 31, `rd_data_o` is the `status_i` value from the read cycle. For any other address it is zero.
- R10: Hard reset (`rst_n` low) clears the test seed, both word banks, `seed_o`, `pers_o` and all strobes to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Write word address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 6 | Read word address |
| status_i | input | 32 | Status word returned for reads in the secret window |
| ctl_ext_seed | input | 1 | Select external seed words |
| ctl_test_mode | input | 1 | Test mode |
| ctl_pers_off | input | 1 | Force personalization to zero |
| ctl_src_en | input | 1 | Entropy source enable |
| ctl_soft_rst | input | 1 | Soft reset of the generator |
| hold_rst | input | 1 | Block-level reset register bit |
| osc_en | input | 1 | Oscillator enable |
| reseed_req | input | 1 | Request a reseed from the selected source |
| entropy_i | input | 384 | Entropy input |
| seed_o | output | 384 | Captured seed |
| pers_o | output | 384 | Captured personalization value |
| reseed_o | output | 1 | One-cycle reseed strobe |
| regen_o | output | 1 | One-cycle regeneration strobe |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 32 | Read data |

## Verification
The bench builds the block with its default parameters: twelve 32-bit words per bank and a 128-bit test seed. At these sizes, 132 serial test writes push bits across the 63-to-64 half boundary and past bit 127. Every reseed is also checked against the full 384-bit seed and personalization values. Each of the five gating inputs is dropped on its own to show that the write is rejected. The read window is probed at both ends, in its unused gap and just outside it.

// File: rtl/seedsel_pkg.sv
package seedsel_pkg;

    typedef enum logic [1:0] {
        SRC_ENTROPY = 2'd0,
        SRC_TEST    = 2'd1,
        SRC_EXT     = 2'd2
    } seed_src_e;

endpackage

// File: rtl/seedsel_word_bank.sv
module seedsel_word_bank #(
    parameter int WORD_W  = 32,
    parameter int N_WORDS = 12,
    parameter int ADDR_W  = 6,
    parameter int BASE    = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [WORD_W-1:0]         wr_data,
    output logic [N_WORDS*WORD_W-1:0] words_o
);
    localparam int BANK_W = N_WORDS * WORD_W;

    logic [N_WORDS-1:0] hit;
    logic [BANK_W-1:0]  words_d, words_q;

    for (genvar g = 0; g < N_WORDS; g++) begin : g_dec
        assign hit[g] = wr_en && (wr_addr == ADDR_W'(BASE + g));
    end

    always_comb begin
        words_d = words_q;
        for (int i = 0; i < N_WORDS; i++) begin
            if (hit[i]) begin
                words_d[i*WORD_W +: WORD_W] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            words_q <= '0;
        end else begin
            words_q <= words_d;
        end
    end

    assign words_o = words_q;

    // R1: the first word of the bank takes the written data
    a_r1_word0_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(BASE)) |=> words_o[WORD_W-1:0] == $past(wr_data));

endmodule

// File: rtl/seedsel_tshift.sv
module seedsel_tshift #(
    parameter int TSEED_W = 128
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_en,
    input  logic               bit_in,
    output logic [TSEED_W-1:0] tseed_o,
    output logic [TSEED_W-1:0] tseed_next_o
);
    localparam int HALF = TSEED_W / 2;

    logic [TSEED_W-1:0] tseed_d, tseed_q;

    always_comb begin
        tseed_d = tseed_q;
        if (shift_en) begin
            tseed_d = {tseed_q[TSEED_W-2:0], bit_in};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tseed_q <= '0;
        end else begin
            tseed_q <= tseed_d;
        end
    end

    assign tseed_o      = tseed_q;
    assign tseed_next_o = tseed_d;

    // R4: the serial bit lands at the LSB
    a_r4_lsb_in: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> tseed_q[0] == $past(bit_in));

    // R4: the top bit of the lower half carries into the upper half
    a_r4_half_carry: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> tseed_q[HALF] == $past(tseed_q[HALF-1]));

    // R5: without an accepted write, the test seed holds
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(tseed_q));

endmodule

// File: rtl/seedsel_pick.sv
module seedsel_pick
    import seedsel_pkg::*;
#(
    parameter int SEED_W  = 384,
    parameter int TSEED_W = 128
) (
    input  logic               ext_sel,
    input  logic               test_sel,
    input  logic               pers_off,
    input  logic [SEED_W-1:0]  ext_seed,
    input  logic [TSEED_W-1:0] test_seed,
    input  logic [SEED_W-1:0]  entropy,
    input  logic [SEED_W-1:0]  pers_words,
    output logic [SEED_W-1:0]  seed_o,
    output logic [SEED_W-1:0]  pers_o
);
    seed_src_e          src;
    logic [SEED_W-1:0]  test_wide;

    if (TSEED_W < SEED_W) begin : g_zext
        assign test_wide = {{(SEED_W-TSEED_W){1'b0}}, test_seed};
    end else begin : g_trunc
        assign test_wide = test_seed[SEED_W-1:0];
    end

    always_comb begin
        if (ext_sel) begin
            src = SRC_EXT;
        end else if (test_sel) begin
            src = SRC_TEST;
        end else begin
            src = SRC_ENTROPY;
        end
        case (src)
            SRC_EXT:  seed_o = ext_seed;
            SRC_TEST: seed_o = test_wide;
            default:  seed_o = entropy;
        endcase
        pers_o = pers_off ? '0 : pers_words;
    end

endmodule

// File: rtl/seedsel_core.sv
module seedsel_core #(
    parameter int WORD_W    = 32,
    parameter int N_WORDS   = 12,
    parameter int TSEED_W   = 128,
    parameter int ADDR_W    = 6,
    parameter int SEED_BASE = 16,
    parameter int PERS_BASE = 32,
    parameter int TBIT_ADDR = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [WORD_W-1:0]         wr_data,
    input  logic                      rd_en,
    input  logic [ADDR_W-1:0]         rd_addr,
    input  logic [WORD_W-1:0]         status_i,
    input  logic                      ctl_ext_seed,
    input  logic                      ctl_test_mode,
    input  logic                      ctl_pers_off,
    input  logic                      ctl_src_en,
    input  logic                      ctl_soft_rst,
    input  logic                      hold_rst,
    input  logic                      osc_en,
    input  logic                      reseed_req,
    input  logic [N_WORDS*WORD_W-1:0] entropy_i,
    output logic [N_WORDS*WORD_W-1:0] seed_o,
    output logic [N_WORDS*WORD_W-1:0] pers_o,
    output logic                      reseed_o,
    output logic                      regen_o,
    output logic                      rd_valid_o,
    output logic [WORD_W-1:0]         rd_data_o
);
    localparam int SEED_W   = N_WORDS * WORD_W;
    localparam int RANGE_LO = SEED_BASE;
    localparam int RANGE_HI = PERS_BASE + N_WORDS - 1;

    typedef struct packed {
        logic [SEED_W-1:0] seed;
        logic [SEED_W-1:0] pers;
        logic              reseed;
        logic              regen_arm;
        logic              regen;
        logic              rd_valid;
        logic [WORD_W-1:0] rd_data;
    } state_t;

    state_t st_d, st_q;

    logic               src_live;
    logic               tbit_accept;
    logic [SEED_W-1:0]  ext_words;
    logic [SEED_W-1:0]  pers_words;
    logic [TSEED_W-1:0] tseed_cur;
    logic [TSEED_W-1:0] tseed_next;
    logic [SEED_W-1:0]  pick_seed;
    logic [SEED_W-1:0]  pick_pers;
    logic               rd_in_window;

    assign src_live    = !hold_rst && !ctl_soft_rst && ctl_src_en && osc_en;
    assign tbit_accept = wr_en && (wr_addr == ADDR_W'(TBIT_ADDR))
                         && ctl_test_mode && src_live;

    seedsel_word_bank #(
        .WORD_W (WORD_W),
        .N_WORDS(N_WORDS),
        .ADDR_W (ADDR_W),
        .BASE   (SEED_BASE)
    ) u_seed_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .words_o(ext_words)
    );

    seedsel_word_bank #(
        .WORD_W (WORD_W),
        .N_WORDS(N_WORDS),
        .ADDR_W (ADDR_W),
        .BASE   (PERS_BASE)
    ) u_pers_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .words_o(pers_words)
    );

    seedsel_tshift #(
        .TSEED_W(TSEED_W)
    ) u_tshift (
        .clk         (clk),
        .rst_n       (rst_n),
        .shift_en    (tbit_accept),
        .bit_in      (wr_data[0]),
        .tseed_o     (tseed_cur),
        .tseed_next_o(tseed_next)
    );

    seedsel_pick #(
        .SEED_W (SEED_W),
        .TSEED_W(TSEED_W)
    ) u_pick (
        .ext_sel   (ctl_ext_seed),
        .test_sel  (ctl_test_mode),
        .pers_off  (ctl_pers_off),
        .ext_seed  (ext_words),
        .test_seed (tseed_next),
        .entropy   (entropy_i),
        .pers_words(pers_words),
        .seed_o    (pick_seed),
        .pers_o    (pick_pers)
    );

    assign rd_in_window = (rd_addr >= ADDR_W'(RANGE_LO)) && (rd_addr <= ADDR_W'(RANGE_HI));

    always_comb begin
        st_d           = st_q;
        st_d.reseed    = tbit_accept || reseed_req;
        st_d.regen_arm = tbit_accept;
        st_d.regen     = st_q.regen_arm;
        if (st_d.reseed) begin
            st_d.seed = pick_seed;
            st_d.pers = pick_pers;
        end
        st_d.rd_valid = rd_en;
        st_d.rd_data  = (rd_en && rd_in_window) ? status_i : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign seed_o     = st_q.seed;
    assign pers_o     = st_q.pers;
    assign reseed_o   = st_q.reseed;
    assign regen_o    = st_q.regen;
    assign rd_valid_o = st_q.rd_valid;
    assign rd_data_o  = st_q.rd_data;

    // R6: regeneration always directly follows a reseed
    a_r6_regen_follows: assert property (@(posedge clk) disable iff (!rst_n)
        regen_o |-> $past(reseed_o));

    // R6: a reseed from a test write carries the new test seed when test mode wins
    a_r6_seed_fresh: assert property (@(posedge clk) disable iff (!rst_n)
        (tbit_accept && !ctl_ext_seed) |=> seed_o[TSEED_W-1:0] == tseed_cur);

    // R8: outputs move only with a reseed strobe
    a_r8_seed_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !reseed_o |-> ($stable(seed_o) && $stable(pers_o)));

    // R3: a forced-off personalization captures zero
    a_r3_pers_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reseed_o && $past(ctl_pers_off)) |-> pers_o == '0);

    // R9: read data appears exactly one cycle after a read
    a_r9_read_lat: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> $past(rd_en));

    // R5: a gated-off source never produces a strobe from a test write
    a_r5_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_live && !reseed_req) |=> !reseed_o);

endmodule

// File: tb/seedsel_core_tb.sv
module seedsel_core_tb;
    localparam int CLK_P  = 10;
    localparam int WW     = 32;
    localparam int NW     = 12;
    localparam int SW     = WW * NW;
    localparam int TW     = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [5:0]    wr_addr = '0;
    logic [WW-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic [5:0]    rd_addr = '0;
    logic [WW-1:0] status_i = '0;
    logic          ctl_ext_seed = 1'b0, ctl_test_mode = 1'b0, ctl_pers_off = 1'b0;
    logic          ctl_src_en = 1'b0, ctl_soft_rst = 1'b0, hold_rst = 1'b0, osc_en = 1'b0;
    logic          reseed_req = 1'b0;
    logic [SW-1:0] entropy_i = '0;
    logic [SW-1:0] seed_o, pers_o;
    logic          reseed_o, regen_o, rd_valid_o;
    logic [WW-1:0] rd_data_o;

    seedsel_core u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .status_i(status_i),
        .ctl_ext_seed(ctl_ext_seed), .ctl_test_mode(ctl_test_mode), .ctl_pers_off(ctl_pers_off),
        .ctl_src_en(ctl_src_en), .ctl_soft_rst(ctl_soft_rst), .hold_rst(hold_rst),
        .osc_en(osc_en), .reseed_req(reseed_req), .entropy_i(entropy_i),
        .seed_o(seed_o), .pers_o(pers_o), .reseed_o(reseed_o), .regen_o(regen_o),
        .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o)
    );

    always #(CLK_P/2) clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;

    // scoreboard queues
    logic [SW-1:0] q_seed[$];
    logic [SW-1:0] q_pers[$];
    bit            q_regen[$];
    string         q_tag[$];
    logic [WW-1:0] q_rd[$];
    bit            pend_regen = 1'b0;
    bit            pend_valid = 1'b0;

    // bench model
    logic [SW-1:0] m_ext = '0;
    logic [SW-1:0] m_pers = '0;
    logic [TW-1:0] m_ts = '0;

    task automatic chk(input bit ok, input string tag, input logic [SW-1:0] act,
                       input logic [SW-1:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [SW-1:0] exp_seed();
        if (ctl_ext_seed) return m_ext;
        if (ctl_test_mode) return {{(SW-TW){1'b0}}, m_ts};
        return entropy_i;
    endfunction

    function automatic logic [SW-1:0] exp_pers();
        return ctl_pers_off ? '0 : m_pers;
    endfunction

    // monitor
    always @(negedge clk) begin
        if (!rst_n) begin
            pend_valid = 1'b0;
        end else begin
            if (pend_valid || regen_o) begin
                chk(regen_o == (pend_valid && pend_regen), "R6/R7 regen strobe",
                    SW'(regen_o), SW'(pend_valid && pend_regen));
            end
            pend_valid = 1'b0;
            if (reseed_o) begin
                if (q_seed.size() == 0) begin
                    chk(1'b0, "R5 unexpected reseed", SW'(1), SW'(0));
                end else begin
                    logic [SW-1:0] es, ep;
                    string tg;
                    es = q_seed.pop_front();
                    ep = q_pers.pop_front();
                    tg = q_tag.pop_front();
                    pend_regen = q_regen.pop_front();
                    pend_valid = 1'b1;
                    chk(seed_o == es, {tg, " seed"}, seed_o, es);
                    chk(pers_o == ep, {tg, " pers"}, pers_o, ep);
                end
            end
            if (rd_valid_o) begin
                if (q_rd.size() == 0) begin
                    chk(1'b0, "R9 unexpected read", SW'(1), SW'(0));
                end else begin
                    logic [WW-1:0] er;
                    er = q_rd.pop_front();
                    chk(rd_data_o == er, "R9 read data", SW'(rd_data_o), SW'(er));
                end
            end
        end
    end

    task automatic push(input bit regen, input string tag);
        q_seed.push_back(exp_seed());
        q_pers.push_back(exp_pers());
        q_regen.push_back(regen);
        q_tag.push_back(tag);
    endtask

    task automatic wr(input logic [5:0] a, input logic [WW-1:0] d);
        wr_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic bit accepts();
        return ctl_test_mode && ctl_src_en && osc_en && !hold_rst && !ctl_soft_rst;
    endfunction

    task automatic tbit(input bit b, input string tag);
        if (accepts()) begin
            m_ts = {m_ts[TW-2:0], b};
            push(1'b1, tag);
        end
        wr(6'd5, {31'h1234_5678 >> 1, b});
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic reseed(input string tag);
        push(1'b0, tag);
        reseed_req = 1'b1;
        @(negedge clk);
        reseed_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input logic [5:0] a, input logic [WW-1:0] st, input bit inwin);
        q_rd.push_back(inwin ? st : '0);
        rd_addr = a; status_i = st; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic hard_reset();
        rst_n = 1'b0;
        m_ext = '0; m_pers = '0; m_ts = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 100000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NW; i++) entropy_i[i*WW +: WW] = 32'hE000_0000 ^ (i * 32'h0101_0307);
        @(negedge clk);
        @(negedge clk);
        // R10: reset values
        chk(seed_o == '0, "R10 seed after reset", seed_o, '0);
        chk(pers_o == '0, "R10 pers after reset", pers_o, '0);
        chk({reseed_o, regen_o, rd_valid_o} == 3'b000, "R10 strobes after reset",
            SW'({reseed_o, regen_o, rd_valid_o}), '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R3: fill banks
        for (int i = 0; i < NW; i++) begin
            logic [WW-1:0] v;
            v = 32'hA500_0000 + i * 32'h0011_0101;
            m_ext[i*WW +: WW] = v;
            wr(6'(16 + i), v);
            v = 32'h3C00_0000 ^ (i * 32'h0707_0001);
            m_pers[i*WW +: WW] = v;
            wr(6'(32 + i), v);
        end
        @(negedge clk);
        // R8: bank writes alone do not move outputs
        chk(seed_o == '0 && pers_o == '0, "R8 no change on word write", seed_o, '0);

        ctl_ext_seed = 1'b1;
        reseed("R1/R2/R7 external seed");
        ctl_pers_off = 1'b1;
        reseed("R3 pers forced off");
        ctl_pers_off = 1'b0;
        ctl_ext_seed = 1'b0;
        reseed("R2 entropy source");

        // R5: rejected writes with each gate dropped
        ctl_src_en = 1'b1; osc_en = 1'b1;
        tbit(1'b1, "R5 test mode off");
        ctl_test_mode = 1'b1;
        ctl_src_en = 1'b0; tbit(1'b1, "R5 src off"); ctl_src_en = 1'b1;
        osc_en = 1'b0;     tbit(1'b1, "R5 osc off"); osc_en = 1'b1;
        hold_rst = 1'b1;   tbit(1'b1, "R5 hold reset"); hold_rst = 1'b0;
        ctl_soft_rst = 1'b1; tbit(1'b1, "R5 soft reset"); ctl_soft_rst = 1'b0;

        // R4 / R6: long shift crossing the half boundary and the top
        for (int k = 0; k < 132; k++) begin
            tbit(bit'((k * 7 + k / 3) % 2), "R4/R6 test shift");
        end

        // R8: bank write after reseed leaves outputs alone
        begin
            logic [SW-1:0] held;
            held = seed_o;
            m_ext[WW-1:0] = 32'h0BAD_F00D;
            wr(6'd16, 32'h0BAD_F00D);
            @(negedge clk);
            chk(seed_o == held, "R8 hold after bank write", seed_o, held);
        end

        // R2: external wins over test mode on a test-bit write
        ctl_ext_seed = 1'b1;
        tbit(1'b0, "R2 ext over test");
        ctl_ext_seed = 1'b0;

        // R9: read window
        rd(6'd16, 32'h1111_2222, 1'b1);
        rd(6'd29, 32'h3333_4444, 1'b1);
        rd(6'd43, 32'h5555_6666, 1'b1);
        rd(6'd44, 32'h7777_8888, 1'b0);
        rd(6'd15, 32'h9999_AAAA, 1'b0);
        rd(6'd5,  32'hBBBB_CCCC, 1'b0);

        // R10: hard reset clears test seed and banks
        hard_reset();
        chk(seed_o == '0, "R10 seed after mid-run reset", seed_o, '0);
        tbit(1'b1, "R10 test seed restarted");

        repeat (4) @(negedge clk);
        chk(q_seed.size() == 0, "R6 all expected reseeds seen", SW'(q_seed.size()), '0);
        chk(q_rd.size() == 0, "R9 all expected reads seen", SW'(q_rd.size()), '0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule